// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block lets a processor issue a load early, ahead of stores that might write the same bytes, and find out later whether that early load is still safe to use. Each early (advanced) load records an entry holding its destination register number, its byte address and its access size. Every store that follows is compared against all live entries. Any entry whose byte range overlaps the store's byte range is dropped.

When the program reaches the point where the loaded value is consumed, it issues a verify request for the destination register. A live entry for that register means no conflicting store has been seen, and the early value is good. No entry means the value may be stale, and the caller must load again or run recovery code. A verify request can optionally retire the entry it finds. The table holds a fixed number of entries. When it is full, the entry allocated longest ago is replaced.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset no entry is live, so a verify request for any register reports a miss (`vfy_hit` = 0).
- R2: After an advanced load to register r, a verify request for r in a later cycle reports a hit (`vfy_hit` = 1). `vfy_hit` is combinational and depends on the state at the start of the cycle.
- R3: A verify request for a register that has no live entry reports a miss, even while other registers have live entries.
- R4: Size codes are 0, 1, 2 and 3, meaning 1, 2, 4 and 8 bytes. A store covering bytes [sa, sa+ss) drops an entry covering bytes [la, la+ls) exactly when sa < la+ls and la < sa+ss. All other entries stay live.
- R5: A verify request with `vfy_retire` = 0 leaves its entry live. A request with `vfy_retire` = 1 removes the entry, so the next verify request for that register misses.
- R6: An advanced load to a register that already has a live entry replaces that entry's address and size and uses no second slot. Stores are then compared only with the new range.
- R7: The table has ENTRIES slots. An advanced load to a new register while all slots are live evicts the slot allocated earliest. The evicted register then misses and all other registers still hit.
- R8: When a store and a verify request for an overlapping entry occur in the same cycle, the store acts first and the verify request reports a miss.
- R9: When an advanced load and an overlapping store occur in the same cycle, the new entry is allocated and survives.
- R10: No two live entries ever hold the same register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_valid | input | 1 | Advanced load this cycle |
| adv_reg | input | REG_W | Destination register of the advanced load |
| adv_addr | input | ADDR_W | Byte address of the advanced load |
| adv_size | input | 2 | Size code of the advanced load (0..3 = 1, 2, 4, 8 bytes) |
| st_valid | input | 1 | Store this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Size code of the store |
| vfy_valid | input | 1 | Verify request this cycle |
| vfy_reg | input | REG_W | Register being verified |
| vfy_retire | input | 1 | Remove the entry found by this verify request |
| vfy_hit | output | 1 | Verify request found a live entry that was not hit by this cycle's store |

## Verification
The overlap rule is swept over every pair of load and store size codes, with store addresses stepped byte by byte across and around the loaded range. This separates off-by-one errors at both ends of the range from errors in decoding the size codes. The same-cycle store-and-verify sweep tells whether the store is applied before or after the lookup. The fill-then-overflow sequence tells oldest-first eviction apart from index-based eviction. The repeated-register sequence tells overwriting apart from duplicate allocation.

// File: rtl/spec_load_tracker.sv
module spec_load_tracker #(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_valid,
  input  logic [REG_W-1:0]  adv_reg,
  input  logic [ADDR_W-1:0] adv_addr,
  input  logic [1:0]        adv_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              vfy_valid,
  input  logic [REG_W-1:0]  vfy_reg,
  input  logic              vfy_retire,
  output logic              vfy_hit
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int XW = ADDR_W + 1;

  logic [ENTRIES-1:0] live;
  logic [REG_W-1:0]   tag   [ENTRIES];
  logic [ADDR_W-1:0]  base  [ENTRIES];
  logic [1:0]         szc   [ENTRIES];
  logic [ENTRIES-1:0] older [ENTRIES];

  logic [ENTRIES-1:0] st_kill, vfy_match, adv_match, oldest, alloc_oh;
  logic [IW-1:0]      alloc_idx;

  function automatic logic [XW-1:0] span(input logic [1:0] c);
    return XW'(1) << c;
  endfunction

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      st_kill[i]   = live[i] && ((XW'(st_addr) < XW'(base[i]) + span(szc[i])) &&
                                 (XW'(base[i]) < XW'(st_addr) + span(st_size)));
      vfy_match[i] = live[i] && (tag[i] == vfy_reg);
      adv_match[i] = live[i] && (tag[i] == adv_reg);
      oldest[i]    = live[i] && (&(older[i] | ~live | (ENTRIES'(1) << i)));
    end
  end

  assign vfy_hit = vfy_valid && |(vfy_match & ~(st_valid ? st_kill : '0));

  always_comb begin
    alloc_idx = '0;
    if (|adv_match) begin
      for (int i = ENTRIES-1; i >= 0; i--) if (adv_match[i]) alloc_idx = IW'(i);
    end else if (~&live) begin
      for (int i = ENTRIES-1; i >= 0; i--) if (!live[i]) alloc_idx = IW'(i);
    end else begin
      for (int i = ENTRIES-1; i >= 0; i--) if (oldest[i]) alloc_idx = IW'(i);
    end
    alloc_oh = adv_valid ? (ENTRIES'(1) << alloc_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i]   <= '0;
        base[i]  <= '0;
        szc[i]   <= '0;
        older[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (st_valid && st_kill[i]) live[i] <= 1'b0;
        if (vfy_valid && vfy_retire && vfy_match[i]) live[i] <= 1'b0;
        if (alloc_oh[i]) begin
          live[i]  <= 1'b1;
          tag[i]   <= adv_reg;
          base[i]  <= adv_addr;
          szc[i]   <= adv_size;
          older[i] <= '0;
          for (int j = 0; j < ENTRIES; j++)
            if (j != i) older[j][i] <= 1'b1;
        end
      end
    end
  end

  function automatic logic has_tag(input logic [REG_W-1:0] r);
    logic f;
    f = 1'b0;
    for (int i = 0; i < ENTRIES; i++) if (live[i] && tag[i] == r) f = 1'b1;
    return f;
  endfunction

  logic dup_tag;
  always_comb begin
    dup_tag = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (live[i] && live[j] && tag[i] == tag[j]) dup_tag = 1'b1;
  end

  // R10
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_tag);

  // R2 R9
  alloc_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_valid |=> has_tag($past(adv_reg)));

  // R4
  store_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> ((live & $past(st_kill & ~alloc_oh)) == '0));

  // R5
  retire_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_valid && vfy_retire && !(adv_valid && adv_reg == vfy_reg)) |=> !has_tag($past(vfy_reg)));

  // R5
  keep_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_hit && !vfy_retire && !st_valid) |=> has_tag($past(vfy_reg)));

  // R7
  one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(oldest));
endmodule

// File: tb/spec_load_tracker_tb.sv
module spec_load_tracker_tb;
  localparam int E = 8, RW = 5, AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic adv_valid = 0, st_valid = 0, vfy_valid = 0, vfy_retire = 0;
  logic [RW-1:0] adv_reg = '0, vfy_reg = '0;
  logic [AW-1:0] adv_addr = '0, st_addr = '0;
  logic [1:0] adv_size = '0, st_size = '0;
  logic vfy_hit;
  int errors = 0, checks = 0;
  logic got;

  spec_load_tracker #(.ENTRIES(E), .REG_W(RW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .adv_valid(adv_valid), .adv_reg(adv_reg), .adv_addr(adv_addr), .adv_size(adv_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .vfy_valid(vfy_valid), .vfy_reg(vfy_reg), .vfy_retire(vfy_retire),
    .vfy_hit(vfy_hit));

  always #2 clk = ~clk;

  task automatic expect_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: vfy_hit=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cycle(input logic lv, input int lr, input int la, input int ls,
                       input logic sv, input int sa, input int ss,
                       input logic cv, input int cr, input logic cc, output logic hit);
    @(negedge clk);
    adv_valid = lv; adv_reg = RW'(lr); adv_addr = AW'(la); adv_size = 2'(ls);
    st_valid = sv; st_addr = AW'(sa); st_size = 2'(ss);
    vfy_valid = cv; vfy_reg = RW'(cr); vfy_retire = cc;
    #1 hit = vfy_hit;
    @(posedge clk); #1;
    adv_valid = 0; st_valid = 0; vfy_valid = 0; vfy_retire = 0;
  endtask

  task automatic do_load(input int r, input int a, input int s);
    logic h; cycle(1, r, a, s, 0, 0, 0, 0, 0, 0, h);
  endtask
  task automatic do_store(input int a, input int s);
    logic h; cycle(0, 0, 0, 0, 1, a, s, 0, 0, 0, h);
  endtask
  task automatic do_vfy(input int r, input logic ret, output logic h);
    cycle(0, 0, 0, 0, 0, 0, 0, 1, r, ret, h);
  endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
  endtask

  function automatic logic ovl(input int la, input int ls, input int sa, input int ss);
    return (sa < la + (1 << ls)) && (la < sa + (1 << ss));
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      do_vfy(r, 0, got); expect_bit(got, 0, "R1 reset");
    end

    // R2 / R3 basic hit and miss
    do_load(5, 100, 2);
    do_vfy(5, 0, got); expect_bit(got, 1, "R2 hit after load");
    do_vfy(6, 0, got); expect_bit(got, 0, "R3 miss other reg");
    // R5 plain verify keeps, retire removes
    do_vfy(5, 0, got); expect_bit(got, 1, "R5 still live");
    do_vfy(5, 1, got); expect_bit(got, 1, "R5 retire reports hit");
    do_vfy(5, 0, got); expect_bit(got, 0, "R5 gone after retire");

    // R4 exhaustive overlap sweep
    for (int ls = 0; ls < 4; ls++)
      for (int ss = 0; ss < 4; ss++)
        for (int sa = 24; sa < 48; sa++) begin
          do_load(3, 32, ls);
          do_store(sa, ss);
          do_vfy(3, 1, got);
          expect_bit(got, !ovl(32, ls, sa, ss), "R4 overlap sweep");
        end

    // R8 store and verify in the same cycle
    for (int sa = 28; sa < 40; sa++) begin
      do_load(4, 32, 2);
      cycle(0, 0, 0, 0, 1, sa, 0, 1, 4, 0, got);
      expect_bit(got, !ovl(32, 2, sa, 0), "R8 same-cycle store first");
      do_vfy(4, 1, got);
      expect_bit(got, !ovl(32, 2, sa, 0), "R8 state after");
    end

    // R9 load and overlapping store in the same cycle
    cycle(1, 7, 64, 3, 1, 66, 1, 0, 0, 0, got);
    do_vfy(7, 1, got); expect_bit(got, 1, "R9 new entry survives");

    // R6 overwrite moves range
    do_reset();
    do_load(1, 200, 2);
    do_load(1, 300, 2);
    do_store(200, 2);
    do_vfy(1, 0, got); expect_bit(got, 1, "R6 old range ignored");
    do_store(302, 0);
    do_vfy(1, 0, got); expect_bit(got, 0, "R6 new range compared");

    // R6 overwrite uses no second slot
    do_reset();
    do_load(1, 0, 0);
    do_load(1, 8, 0);
    for (int r = 2; r <= E; r++) do_load(r, 16 * r, 0);
    for (int r = 1; r <= E; r++) begin
      do_vfy(r, 0, got); expect_bit(got, 1, "R6 single slot");
    end

    // R7 oldest eviction
    do_reset();
    for (int r = 0; r < E; r++) do_load(10 + r, 16 * r, 0);
    do_load(20, 500, 0);
    do_vfy(10, 0, got); expect_bit(got, 0, "R7 oldest evicted");
    for (int r = 1; r < E; r++) begin
      do_vfy(10 + r, 0, got); expect_bit(got, 1, "R7 others kept");
    end
    do_vfy(20, 0, got); expect_bit(got, 1, "R7 newcomer live");
    do_load(21, 520, 0);
    do_vfy(11, 0, got); expect_bit(got, 0, "R7 next oldest evicted");
    do_vfy(12, 0, got); expect_bit(got, 1, "R7 third kept");

    // R10 repeated loads never duplicate: retire once clears register
    do_reset();
    do_load(2, 40, 0); do_load(2, 44, 0); do_load(2, 48, 0);
    do_vfy(2, 1, got); expect_bit(got, 1, "R10 present");
    do_vfy(2, 0, got); expect_bit(got, 0, "R10 no duplicate left");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule